// File: doc/BRIEF.md
# Byte and Halfword Swap Unit with Flags

This block rearranges the bytes of a 32-bit word in one of three ways and reports condition flags for the result. A 2-bit operation code selects the rearrangement. Code 0 swaps the two bytes inside each halfword. Code 1 reverses the order of all four bytes. Code 2 exchanges the upper and lower halfwords. Code 3 is reserved: the word passes through unchanged and the flags keep their previous values.

Each operation produces four flags: zero (Z), sign (S), carry (CY) and overflow (OV). Z, S and OV follow the same rule for all three operations. The carry flag depends on the operation: each rearrangement sets CY by its own test for a zero byte or a zero halfword. This makes the unit useful for finding a terminator or an empty field in packed data.

The caller presents an operation together with `valid_i`. The rearranged word, the flags and a one-cycle `valid_o` pulse appear after the next rising clock edge. While `valid_i` is low, all outputs hold their last values.

Top module: `swap_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no operation issued, `valid_o`, `result_o` and all four flags are 0.
- R2: Op code 2'b00 swaps the bytes inside each halfword: result = {in[23:16], in[31:24], in[7:0], in[15:8]}.
- R3: Op code 2'b01 reverses the byte order: result = {in[7:0], in[15:8], in[23:16], in[31:24]}.
- R4: Op code 2'b10 exchanges the halfwords: result = {in[15:0], in[31:16]}.
- R5: Op code 2'b11 is reserved. The result equals the input, and Z, S, CY and OV keep the values they had before the operation.
- R6: For op codes 0 to 2, Z is 1 exactly when the result is zero.
- R7: For op codes 0 to 2, S equals bit 31 of the result.
- R8: For op codes 0 to 2, OV is 0.
- R9: For op code 0, CY is 1 when result bits 7:0 are zero or result bits 15:8 are zero.
- R10: For op code 1, CY is 1 when any of the four bytes of the result is zero.
- R11: For op code 2, CY is 1 when result bits 15:0 are zero or result bits 31:16 are zero.
- R12: Outputs update on the rising edge after a cycle with `valid_i` high. `valid_o` is high for exactly that one following cycle. With `valid_i` low, `result_o` and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request for the current cycle |
| op_i | input | 2 | Operation: 0 byte swap within each halfword, 1 full byte reverse, 2 halfword swap, 3 reserved |
| data_i | input | 32 | Input word |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| result_o | output | 32 | Rearranged word |
| flag_z_o | output | 1 | Zero flag |
| flag_s_o | output | 1 | Sign flag |
| flag_cy_o | output | 1 | Carry flag: zero byte or zero halfword, by the rule of each operation |
| flag_ov_o | output | 1 | Overflow flag |

## Verification
Every result and flag is due exactly one rising edge after the cycle in which `valid_i` was high.

The bench drives its inputs on falling edges and drops `valid_i` on the next falling edge. It then reads the outputs at that point, half a cycle after the registering edge. One falling edge later it checks that `valid_o` has returned low and that the result and flags have not moved.

The reserved-code tests use inputs that would change Z, S or CY if those flags were recomputed. This shows that the flags were actually held.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [1:0] {
    OP_HBSWAP = 2'b00,
    OP_WREV   = 2'b01,
    OP_HSWAP  = 2'b10,
    OP_RSVD   = 2'b11
  } swap_op_e;

  typedef struct packed {
    logic z;
    logic s;
    logic cy;
    logic ov;
  } swap_flags_t;
endpackage

// File: rtl/swap_datapath.sv
module swap_datapath #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] result_o
);
  import swap_pkg::*;
  localparam int BYTES  = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int HWORDS = DATA_W / 16;

  logic [DATA_W-1:0] hb_swap, w_rev, h_swap;

  // byte swap inside every 16-bit lane
  for (genvar h = 0; h < HWORDS; h++) begin : g_hb
    assign hb_swap[16*h +: 8]     = data_i[16*h + 8 +: 8];
    assign hb_swap[16*h + 8 +: 8] = data_i[16*h +: 8];
  end

  // full byte order reversal
  for (genvar b = 0; b < BYTES; b++) begin : g_rev
    assign w_rev[8*b +: 8] = data_i[8*(BYTES-1-b) +: 8];
  end

  assign h_swap = {data_i[HALF_W-1:0], data_i[DATA_W-1:HALF_W]};

  always_comb begin
    unique case (swap_op_e'(op_i))
      OP_HBSWAP: result_o = hb_swap;
      OP_WREV:   result_o = w_rev;
      OP_HSWAP:  result_o = h_swap;
      default:   result_o = data_i;
    endcase
  end
endmodule

// File: rtl/swap_flag_gen.sv
module swap_flag_gen #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]            op_i,
  input  logic [DATA_W-1:0]     result_i,
  input  swap_pkg::swap_flags_t prev_i,
  output swap_pkg::swap_flags_t next_o
);
  import swap_pkg::*;
  localparam int BYTES  = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;

  logic [BYTES-1:0] byte_zero;
  logic             lo_half_zero, hi_half_zero;
  logic             cy;

  for (genvar b = 0; b < BYTES; b++) begin : g_bz
    assign byte_zero[b] = (result_i[8*b +: 8] == 8'h00);
  end

  assign lo_half_zero = (result_i[HALF_W-1:0] == '0);
  assign hi_half_zero = (result_i[DATA_W-1:HALF_W] == '0);

  always_comb begin
    unique case (swap_op_e'(op_i))
      OP_HBSWAP: cy = byte_zero[0] | byte_zero[1];
      OP_WREV:   cy = |byte_zero;
      OP_HSWAP:  cy = lo_half_zero | hi_half_zero;
      default:   cy = prev_i.cy;
    endcase
  end

  always_comb begin
    if (swap_op_e'(op_i) == OP_RSVD) begin
      next_o = prev_i;
    end else begin
      next_o.z  = (result_i == '0);
      next_o.s  = result_i[DATA_W-1];
      next_o.cy = cy;
      next_o.ov = 1'b0;
    end
  end
endmodule

// File: rtl/swap_out_reg.sv
module swap_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [DATA_W-1:0]     result_i,
  input  swap_pkg::swap_flags_t flags_i,
  output logic                  valid_o,
  output logic [DATA_W-1:0]     result_o,
  output swap_pkg::swap_flags_t flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= result_i;
        flags_o  <= flags_i;
      end
    end
  end
endmodule

// File: rtl/swap_unit.sv
module swap_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_z_o,
  output logic              flag_s_o,
  output logic              flag_cy_o,
  output logic              flag_ov_o
);
  import swap_pkg::*;

  logic [DATA_W-1:0] comb_result;
  swap_flags_t       next_flags, cur_flags;

  swap_datapath #(.DATA_W(DATA_W)) u_dp (
    .data_i  (data_i),
    .op_i    (op_i),
    .result_o(comb_result)
  );

  swap_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .op_i    (op_i),
    .result_i(comb_result),
    .prev_i  (cur_flags),
    .next_o  (next_flags)
  );

  swap_out_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .result_i(comb_result),
    .flags_i (next_flags),
    .valid_o (valid_o),
    .result_o(result_o),
    .flags_o (cur_flags)
  );

  assign flag_z_o  = cur_flags.z;
  assign flag_s_o  = cur_flags.s;
  assign flag_cy_o = cur_flags.cy;
  assign flag_ov_o = cur_flags.ov;
endmodule

// File: rtl/swap_unit_chk.sv
module swap_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_z_o,
  input logic              flag_s_o,
  input logic              flag_cy_o,
  input logic              flag_ov_o
);
  localparam int HALF_W = DATA_W / 2;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R12
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(flag_z_o) && $stable(flag_cy_o))); // R12
  AST_HSWAP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10) |=>
      result_o == {$past(data_i[HALF_W-1:0]), $past(data_i[DATA_W-1:HALF_W])}); // R4
  AST_RSVD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> (result_o == $past(data_i))); // R5
  AST_RSVD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=>
      ($stable(flag_z_o) && $stable(flag_s_o) && $stable(flag_cy_o) && $stable(flag_ov_o))); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 2'b11) |=> (flag_z_o == (result_o == '0))); // R6
  AST_SIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 2'b11) |=> (flag_s_o == result_o[DATA_W-1])); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !flag_ov_o); // R8
endmodule

bind swap_unit swap_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .data_i   (data_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .flag_z_o (flag_z_o),
  .flag_s_o (flag_s_o),
  .flag_cy_o(flag_cy_o),
  .flag_ov_o(flag_ov_o)
);

// File: tb/swap_unit_tb.sv
module swap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] din = '0;
  logic        valid_out;
  logic [31:0] res;
  logic        fz, fs, fcy, fov;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swap_unit u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid_in),
    .op_i     (op),
    .data_i   (din),
    .valid_o  (valid_out),
    .result_o (res),
    .flag_z_o (fz),
    .flag_s_o (fs),
    .flag_cy_o(fcy),
    .flag_ov_o(fov)
  );

  // {op, input, expected result, expected flags {z,s,cy,ov}}
  localparam int NV = 14;
  localparam logic [69:0] VECS [NV] = '{
    {2'd0, 32'h12345678, 32'h34127856, 4'b0000},
    {2'd0, 32'hAABB00CC, 32'hBBAACC00, 4'b0110},
    {2'd0, 32'h00FF0012, 32'hFF001200, 4'b0110},
    {2'd0, 32'h11223300, 32'h22110033, 4'b0010},
    {2'd0, 32'h00000000, 32'h00000000, 4'b1010},
    {2'd1, 32'h12345678, 32'h78563412, 4'b0000},
    {2'd1, 32'h80FF1001, 32'h0110FF80, 4'b0000},
    {2'd1, 32'h01020380, 32'h80030201, 4'b0100},
    {2'd1, 32'h12003456, 32'h56340012, 4'b0010},
    {2'd2, 32'h12345678, 32'h56781234, 4'b0000},
    {2'd2, 32'h0000ABCD, 32'hABCD0000, 4'b0110},
    {2'd2, 32'h00120034, 32'h00340012, 4'b0000},
    {2'd1, 32'h00000000, 32'h00000000, 4'b1010},
    {2'd2, 32'hFFFF0000, 32'h0000FFFF, 4'b0010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string op_req(input logic [1:0] o);
    case (o)
      2'd0:    return "R2 R9";
      2'd1:    return "R3 R10";
      2'd2:    return "R4 R11";
      default: return "R5";
    endcase
  endfunction

  // drive on a falling edge, drop valid on the next one, then read outputs
  task automatic issue(input logic [1:0] o, input logic [31:0] d);
    @(negedge clk);
    valid_in = 1'b1;
    op = o;
    din = d;
    @(negedge clk);
    valid_in = 1'b0;
    din = ~d;
  endtask

  function automatic logic [31:0] flags4();
    return {28'd0, fz, fs, fcy, fov};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, valid_out}, 32'd0);
    check("R1 result in reset", res, 32'd0);
    check("R1 flags in reset", flags4(), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {res[30:0] | flags4()[30:0], valid_out}, 32'd0);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i][69:68], VECS[i][67:36]);
      check({op_req(VECS[i][69:68]), " result"}, res, VECS[i][35:4]);
      check({op_req(VECS[i][69:68]), " R6 R7 R8 flags"}, flags4(), {28'd0, VECS[i][3:0]});
      check("R12 valid_o due", {31'd0, valid_out}, 32'd1);
    end

    // R12 pulse width and hold while idle
    @(negedge clk);
    din = 32'h00000000;
    op = 2'd1;
    check("R12 valid_o pulse ends", {31'd0, valid_out}, 32'd0);
    @(negedge clk);
    check("R12 result held", res, 32'h0000FFFF);
    check("R12 flags held", flags4(), 32'b0010);

    // R5 reserved: pass-through, flags unchanged (zero input would set Z)
    issue(2'd3, 32'h00000000);
    check("R5 pass zero", res, 32'h00000000);
    check("R5 flags kept", flags4(), 32'b0010);
    issue(2'd1, 32'h01020380);
    held = 4'b0100;
    issue(2'd3, 32'h00120000);
    check("R5 pass word", res, 32'h00120000);
    check("R5 flags kept after S", flags4(), {28'd0, held});

    // back-to-back operations
    @(negedge clk);
    valid_in = 1'b1; op = 2'd0; din = 32'hA1B2C3D4;
    @(negedge clk);
    check("R2 back-to-back first", res, 32'hB2A1D4C3);
    op = 2'd2; din = 32'h0000_0001;
    @(negedge clk);
    valid_in = 1'b0;
    check("R4 R11 back-to-back second", res, 32'h00010000);
    check("R11 back-to-back cy", flags4(), 32'b0010);
    check("R12 valid held high", {31'd0, valid_out}, 32'd1);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset result", res, 32'd0);
    check("R1 mid-run reset flags", flags4(), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule